// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave that stands in front of a byte-wide storage array built from plain registers. It runs on a fast system clock and oversamples the bus clock and data lines. It finds start and stop conditions from the sampled lines. It pulls the data line low through an open-drain enable and never drives it high. A master selects the block with a device address byte. The upper four bits of that byte are the fixed code 1010 and the next three bits must equal the `dev_sel_i` strap pins. The master then either loads a two-byte word address and streams data bytes into one page, or reads bytes back one after another.

Writes go to a 32-byte page buffer first. The stop that closes a write starts a timed internal write cycle of `TWR_CYCLES` system clocks. While that cycle runs the slave ignores the bus completely, and when the cycle ends the buffered bytes are copied into the array. A high level on the write-protect pin stops any commit. The array holds 2^`ADDR_W` bytes: the default of 11 bits gives 2048 bytes, and a setting of 13 gives the full 8192-byte part.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A falling data line while the bus clock is high is a start, and a rising data line while the clock is high is a stop. Bytes clocked on the bus without a preceding start get no acknowledge, and a start always releases the data line.
- R2: The address byte is 1,0,1,0,S2,S1,S0,RW, sent MSB first. When the S bits equal `dev_sel_i`, the slave pulls SDA low during the ninth clock. It also acknowledges every accepted word-address byte and every accepted data byte in the same way.
- R3: An address byte that does not match gets no acknowledge, and the slave ignores all bytes that follow until the next start.
- R4: A write (RW=0) carries a high and a low word-address byte. Only the low `ADDR_W` bits of the 16 bits form the address, and the rest are ignored.
- R5: The data bytes of a write are committed to the array only after the stop and after `TWR_CYCLES` system clocks. The internal write cycle lasts no longer than that.
- R6: During the internal write cycle the slave never drives SDA and does not acknowledge its own device address.
- R7: Successive data bytes of one write go to successive addresses. Only the low 5 address bits advance, so the writes wrap inside the 32-byte page and the page bits never change.
- R8: While `wp_i` is high at the stop, nothing is committed and no write cycle starts, so the slave answers at once. While it is low, writes proceed normally.
- R9: A random read sets the address with a write, then sends a repeated start and an address byte with RW=1, and gets back the stored byte. The slave changes SDA only after falling clock edges, starts or stops.
- R10: A sequential read increments the address after each byte and wraps from the top of the address space to 0. A master acknowledge asks for another byte, and a master no-acknowledge ends the transfer.
- R11: A read that starts directly with RW=1 continues from the address that follows the last byte read.
- R12: After reset the slave does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | High pulls the data line low |
| dev_sel_i | input | 3 | Strapped device select bits |
| wp_i | input | 1 | Write protect, high blocks commits |

## Verification
The checker watches several rules on every cycle. The data-line enable may change only right after a falling clock edge, a start or a stop. The slave stays silent for the whole write cycle, and that cycle never runs longer than `TWR_CYCLES`. A protected stop never starts a cycle, and a start always releases the line. Whether a byte lands at the right address only shows up when the bench reads it back through the bus. The same holds for page wrap, the ignored upper address bits, a protected write leaving old data in place, the top-to-zero read wrap and the current-address read that follows it.

// File: rtl/e2w_pkg.sv
package e2w_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int PAGE_BYTES = 32;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACKWAIT, ST_ACK, ST_TX, ST_MACK, ST_BUSY
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV, PH_AHI, PH_ALO, PH_DATA
    } ph_e;
endpackage

// File: rtl/e2w_line_sync.sv
module e2w_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    // bit 1 is the synchronised level, bit 2 the level one cycle earlier
    assign scl_rise_o = scl_q[1] & ~scl_q[2];
    assign scl_fall_o = ~scl_q[1] & scl_q[2];
    assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    assign sda_o      = sda_q[1];
endmodule

// File: rtl/e2w_write_timer.sv
module e2w_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start_i) begin
            cnt_d  = CW'(CYCLES);
            busy_d = 1'b1;
        end else if (busy_q) begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == CW'(1)) busy_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == CW'(1));
endmodule

// File: rtl/e2w_store.sv
module e2w_store #(
    parameter int AW      = 11,
    parameter int PAGE_AW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  buf_we_i,
    input  logic [PAGE_AW-1:0]    buf_off_i,
    input  logic [7:0]            buf_data_i,
    input  logic                  commit_i,
    input  logic [AW-PAGE_AW-1:0] page_i,
    input  logic [AW-1:0]         rd_addr_i,
    output logic [7:0]            rd_data_o
);
    localparam int PAGE_N = 1 << PAGE_AW;
    localparam int DEPTH  = 1 << AW;

    logic [7:0]        mem [DEPTH];
    logic [7:0]        pbuf [PAGE_N];
    logic [PAGE_N-1:0] pval;

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        logic       v_d, v_q;
        logic [7:0] b_d, b_q;
        always_comb begin
            v_d = v_q;
            b_d = b_q;
            if (clr_i) begin
                v_d = 1'b0;
            end else if (buf_we_i && buf_off_i == PAGE_AW'(g)) begin
                v_d = 1'b1;
                b_d = buf_data_i;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                b_q <= '0;
            end else begin
                v_q <= v_d;
                b_q <= b_d;
            end
        end
        assign pval[g] = v_q;
        assign pbuf[g] = b_q;
    end

    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (pval[i]) mem[{page_i, PAGE_AW'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
    parameter int ADDR_W     = 11,
    parameter int TWR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i
);
    import e2w_pkg::*;

    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int PG_W    = ADDR_W - PAGE_AW;

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [3:0]        cnt;
        logic [7:0]        shf;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] addr;
        logic [PG_W-1:0]   page;
        logic              ack;
        logic              to_tx;
        logic              more;
        logic              pend;
        logic              oe;
    } regs_t;

    regs_t r_d, r_q;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic tstart, tbusy, tdone;
    logic clr, buf_we;
    logic [7:0] rd_data;
    logic busy_w;

    e2w_line_sync sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
    );

    e2w_write_timer #(.CYCLES(TWR_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start_i(tstart),
        .busy_o(tbusy), .done_o(tdone)
    );

    e2w_store #(.AW(ADDR_W), .PAGE_AW(PAGE_AW)) store_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .buf_we_i(buf_we),
        .buf_off_i(r_q.addr[PAGE_AW-1:0]), .buf_data_i({r_q.shf[6:0], sda_s}),
        .commit_i(tdone), .page_i(r_q.page),
        .rd_addr_i(r_q.addr), .rd_data_o(rd_data)
    );

    always_comb begin
        logic [7:0]  byte_in;
        logic [15:0] word;
        r_d     = r_q;
        tstart  = 1'b0;
        clr     = 1'b0;
        buf_we  = 1'b0;
        byte_in = {r_q.shf[6:0], sda_s};
        word    = {r_q.ahi, byte_in};

        if (r_q.st == ST_BUSY) begin
            if (tdone) r_d.st = ST_IDLE;
        end else if (start_det) begin
            r_d.st  = ST_RX;
            r_d.ph  = PH_DEV;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (stop_det) begin
            r_d.oe = 1'b0;
            if (r_q.pend && !wp_i) begin
                r_d.st = ST_BUSY;
                tstart = 1'b1;
            end else begin
                r_d.st = ST_IDLE;
            end
            r_d.pend = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.shf = byte_in;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == 4'd7) begin
                            r_d.st    = ST_ACKWAIT;
                            r_d.ack   = 1'b1;
                            r_d.to_tx = 1'b0;
                            unique case (r_q.ph)
                                PH_DEV: begin
                                    if (byte_in[7:1] != {DEV_CODE, dev_sel_i}) r_d.ack = 1'b0;
                                    else if (byte_in[0]) r_d.to_tx = 1'b1;
                                    else r_d.ph = PH_AHI;
                                end
                                PH_AHI: begin
                                    r_d.ahi = byte_in;
                                    r_d.ph  = PH_ALO;
                                end
                                PH_ALO: begin
                                    r_d.addr = word[ADDR_W-1:0];
                                    r_d.page = word[ADDR_W-1:PAGE_AW];
                                    r_d.pend = 1'b0;
                                    clr      = 1'b1;
                                    r_d.ph   = PH_DATA;
                                end
                                default: begin
                                    buf_we   = 1'b1;
                                    r_d.pend = 1'b1;
                                    r_d.addr = {r_q.addr[ADDR_W-1:PAGE_AW],
                                                r_q.addr[PAGE_AW-1:0] + 1'b1};
                                end
                            endcase
                        end
                    end
                end
                ST_ACKWAIT: begin
                    if (scl_fall) begin
                        r_d.oe = r_q.ack;
                        r_d.st = r_q.ack ? ST_ACK : ST_IDLE;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.to_tx) begin
                            r_d.shf  = rd_data;
                            r_d.oe   = ~rd_data[7];
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.st   = ST_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_MACK;
                        end else begin
                            r_d.shf = {r_q.shf[6:0], 1'b0};
                            r_d.oe  = ~r_q.shf[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.more) begin
                            r_d.shf  = rd_data;
                            r_d.oe   = ~rd_data[7];
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.st   = ST_TX;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_DEV, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;
    assign busy_w   = (r_q.st == ST_BUSY);
endmodule

// File: rtl/e2w_slave_chk.sv
module e2w_slave_chk #(
    parameter int TWR = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic wp
);
    localparam int CW = $clog2(TWR + 2);
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else busy_cnt <= '0;
    end

    AST_OE_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R9
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe); // R6
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= CW'(TWR))); // R5
    AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && wp && !busy) |=> !busy); // R8
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> !sda_oe); // R1
endmodule

bind eeprom_2w_slave e2w_slave_chk #(.TWR(TWR_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .busy(busy_w), .wp(wp_i)
);

// File: tb/eeprom_2w_slave_tb_top.sv
module eeprom_2w_slave_tb_top;
    localparam int AW  = 11;
    localparam int TWR = 300;
    localparam int Q   = 6;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [7:0] pat [8];
    logic [7:0] got [8];

    always #2.5 clk = ~clk;

    eeprom_2w_slave #(.ADDR_W(AW), .TWR_CYCLES(TWR)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .dev_sel_i(SEL), .wp_i(wp)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_bit(input logic v, output logic s);
        scl = 1'b0; wq();
        sda_m = v; wq();
        scl = 1'b1; wq();
        s = sda_line; wq();
        scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        scl = 1'b0; sda_m = 1'b0; wq();
        scl = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~mack, s);
    endtask

    task automatic write_seq(input logic [15:0] a, input int n, input string req);
        logic k;
        bus_start();
        wr_byte(DEV_W, k);   chk(k, req, k, 1);
        wr_byte(a[15:8], k); chk(k, req, k, 1);
        wr_byte(a[7:0], k);  chk(k, req, k, 1);
        for (int i = 0; i < n; i++) begin
            wr_byte(pat[i], k); chk(k, req, k, 1);
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input string req);
        logic k;
        bus_start();
        wr_byte(DEV_W, k);   chk(k, req, k, 1);
        wr_byte(a[15:8], k);
        wr_byte(a[7:0], k);
        bus_start();
        wr_byte(DEV_R, k);   chk(k, req, k, 1);
        for (int i = 0; i < n; i++) rd_byte(i != n - 1, got[i]);
        bus_stop();
    endtask

    task automatic wait_wr();
        repeat (TWR + 40) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R12", sda_oe, 0);
    endtask

    task automatic t_no_start();
        logic k;
        wr_byte(DEV_W, k);
        chk(!k, "R1", k, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic k;
        bus_start();
        wr_byte({4'b1010, ~SEL, 1'b0}, k); chk(!k, "R3", k, 0);
        wr_byte(DEV_W, k);                 chk(!k, "R3", k, 0);
        bus_stop();
    endtask

    task automatic t_byte_write();
        pat[0] = 8'h5A;
        write_seq(16'h0123, 1, "R2");
        wait_wr();
        read_seq(16'h0123, 1, "R9");
        chk(got[0] == 8'h5A, "R9", got[0], 8'h5A);
    endtask

    task automatic t_busy();
        logic k;
        pat[0] = 8'h11;
        write_seq(16'h0200, 1, "R5");
        bus_start();
        wr_byte(DEV_W, k); chk(!k, "R6", k, 0);
        bus_stop();
        wait_wr();
        read_seq(16'h0200, 1, "R5");
        chk(got[0] == 8'h11, "R5", got[0], 8'h11);
    endtask

    task automatic t_upper();
        pat[0] = 8'h77;
        write_seq(16'hF830, 1, "R4");
        wait_wr();
        read_seq(16'h0030, 1, "R4");
        chk(got[0] == 8'h77, "R4", got[0], 8'h77);
    endtask

    task automatic t_page();
        pat[0] = 8'h01; pat[1] = 8'h02; pat[2] = 8'h03; pat[3] = 8'h04;
        write_seq(16'h005E, 4, "R7");
        wait_wr();
        read_seq(16'h005E, 2, "R7");
        chk(got[0] == 8'h01, "R7", got[0], 8'h01);
        chk(got[1] == 8'h02, "R7", got[1], 8'h02);
        read_seq(16'h0040, 2, "R7");
        chk(got[0] == 8'h03, "R7", got[0], 8'h03);
        chk(got[1] == 8'h04, "R7", got[1], 8'h04);
    endtask

    task automatic t_wp();
        pat[0] = 8'hEE;
        wp = 1'b1;
        write_seq(16'h0123, 1, "R8");
        read_seq(16'h0123, 1, "R8");
        chk(got[0] == 8'h5A, "R8", got[0], 8'h5A);
        wp = 1'b0;
    endtask

    task automatic t_seq();
        logic k;
        logic [7:0] b;
        pat[0] = 8'hC1; pat[1] = 8'hC2;
        write_seq(16'h07FE, 2, "R10");
        wait_wr();
        pat[0] = 8'hD0; pat[1] = 8'hD1;
        write_seq(16'h0000, 2, "R10");
        wait_wr();
        read_seq(16'h07FE, 3, "R10");
        chk(got[0] == 8'hC1, "R10", got[0], 8'hC1);
        chk(got[1] == 8'hC2, "R10", got[1], 8'hC2);
        chk(got[2] == 8'hD0, "R10", got[2], 8'hD0);
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        bus_start();
        wr_byte(DEV_R, k); chk(k, "R11", k, 1);
        rd_byte(1'b0, b);
        bus_stop();
        chk(b == 8'hD1, "R11", b, 8'hD1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_mismatch();
        t_byte_write();
        t_busy();
        t_upper();
        t_page();
        t_wp();
        t_seq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule